// File: doc/BRIEF.md
# Dual-Lane Scalar Slot Decoder

This block sits in the instruction-issue path of a very-long-instruction-word core. Each cycle it may receive one 512-bit bundle. It pulls out the two scalar-lane instructions that sit near the top of the bundle. For each lane it reports six fields: the operation class, the sub-operation, the predicate bit, the first source register, the second-operand selector and the destination register.

The two lanes are not symmetric. The upper lane (lane 0) may carry any operation, control transfers included. The lower lane (lane 1) has the same field layout shifted down by a fixed stride. Lane 1 may only carry arithmetic and halt operations. A branch or call found in lane 1 is a decode-time legality violation. The block raises a flag for it and withholds the lane's issue enable.

A parameterised list of (class, sub-operation) pairs identifies the control-transfer family. All results are registered on a clock enable, one cycle after the bundle is presented.

Top module: `scalar_slot_decoder`

## Requirements
- R1: Lane 0 fields are taken from absolute bundle bits (LSB = bit 0): predicate at 503, class [502:499], sub-operation [498:493], source register [492:488], operand selector [487:482], destination register [481:477].
- R2: Every lane-1 field is taken from the bit positions 27 below its lane-0 counterpart: predicate at 476, class [475:472], sub-operation [471:466], source register [465:461], operand selector [460:455], destination register [454:450].
- R3: On a rising edge with `en` high, `out_valid` takes the value of `bundle_valid`, and all decoded fields take the current bundle's values, so results appear one cycle after presentation.
- R4: On a rising edge with `en` low, every output keeps its previous value.
- R5: `l0_issue` is high exactly when `out_valid` is high and the registered lane-0 predicate bit is 1. A lane whose predicate is 0 still reports its fields.
- R6: With the default list, the control-transfer family is class 15 with sub-operation 0, 1, 2 or 3. When a valid bundle carries such an op in lane 1, `lane1_illegal` is high in the output cycle and `l1_issue` is low.
- R7: `l1_issue` is high exactly when `out_valid` is high, the lane-1 predicate bit is 1 and `lane1_illegal` is low. Lane 0 is never flagged, whatever op it carries.
- R8: While `rst_n` is low, `out_valid`, both issue outputs, `lane1_illegal` and all field outputs are 0.
- R9: When `out_valid` is low, `l0_issue`, `l1_issue` and `lane1_illegal` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Clock enable for all output registers |
| bundle_valid | input | 1 | The bundle on `bundle` is meaningful |
| bundle | input | 512 | Instruction bundle |
| out_valid | output | 1 | Registered results belong to a valid bundle |
| l0_pred | output | 1 | Lane 0 predicate bit |
| l0_cls | output | 4 | Lane 0 operation class |
| l0_sub | output | 6 | Lane 0 sub-operation |
| l0_src | output | 5 | Lane 0 source register |
| l0_opnd | output | 6 | Lane 0 operand selector |
| l0_dst | output | 5 | Lane 0 destination register |
| l0_issue | output | 1 | Lane 0 may execute |
| l1_pred | output | 1 | Lane 1 predicate bit |
| l1_cls | output | 4 | Lane 1 operation class |
| l1_sub | output | 6 | Lane 1 sub-operation |
| l1_src | output | 5 | Lane 1 source register |
| l1_opnd | output | 6 | Lane 1 operand selector |
| l1_dst | output | 5 | Lane 1 destination register |
| l1_issue | output | 1 | Lane 1 may execute |
| lane1_illegal | output | 1 | Control transfer found in lane 1 |

## Verification
The checker does not require `bundle_valid` to be a pulse. It only assumes that `en` and `bundle_valid` are known, 2-state values from the first edge after reset. Any bundle content is accepted, because every bit pattern decodes to some field values.

The bench drives inputs only on falling edges, with `en` high except in the stretches where holding is being tested. It sweeps all 1024 (class, sub-operation) pairs in lane 1 and walks lane 0 through the control-transfer encodings. Both predicate values are used, and the bits outside the slots are filled with random values.

// File: rtl/ssd_pkg.sv
package ssd_pkg;
  localparam int CLS_W  = 4;
  localparam int SUB_W  = 6;
  localparam int REG_W  = 5;
  localparam int OPND_W = 6;
  localparam int OP_W   = CLS_W + SUB_W;

  typedef struct packed {
    logic              pred;
    logic [CLS_W-1:0]  cls;
    logic [SUB_W-1:0]  sub;
    logic [REG_W-1:0]  src;
    logic [OPND_W-1:0] opnd;
    logic [REG_W-1:0]  dst;
  } slot_t;

  // Joined (class, sub-operation) key used by the control-transfer matcher
  function automatic logic [OP_W-1:0] op_key(input logic [CLS_W-1:0] c,
                                             input logic [SUB_W-1:0] s);
    return {c, s};
  endfunction
endpackage

// File: rtl/ssd_slot_extract.sv
module ssd_slot_extract
  import ssd_pkg::*;
#(
  parameter int SLOT_W   = 27,
  parameter int PRED_REL = 26,
  parameter int CLS_REL  = 22,
  parameter int SUB_REL  = 16,
  parameter int SRC_REL  = 11,
  parameter int OPND_REL = 5,
  parameter int DST_REL  = 0
) (
  input  logic [SLOT_W-1:0] win,
  output slot_t             fields
);
  always_comb begin
    fields.pred = win[PRED_REL];
    fields.cls  = win[CLS_REL  +: CLS_W];
    fields.sub  = win[SUB_REL  +: SUB_W];
    fields.src  = win[SRC_REL  +: REG_W];
    fields.opnd = win[OPND_REL +: OPND_W];
    fields.dst  = win[DST_REL  +: REG_W];
  end
endmodule

// File: rtl/ssd_cf_match.sv
module ssd_cf_match
  import ssd_pkg::*;
#(
  parameter int                N_CF    = 4,
  parameter logic [N_CF*OP_W-1:0] CF_LIST = '0
) (
  input  logic [CLS_W-1:0] cls,
  input  logic [SUB_W-1:0] sub,
  output logic             hit
);
  logic [N_CF-1:0] entry_hit;
  logic [OP_W-1:0] key;

  assign key = op_key(cls, sub);

  for (genvar i = 0; i < N_CF; i++) begin : g_entry
    assign entry_hit[i] = (key == CF_LIST[i*OP_W +: OP_W]);
  end

  assign hit = |entry_hit;
endmodule

// File: rtl/scalar_slot_decoder.sv
module scalar_slot_decoder
  import ssd_pkg::*;
#(
  parameter int BUNDLE_W    = 512,
  parameter int PRED_POS    = 503,
  parameter int CLS_LSB     = 499,
  parameter int SUB_LSB     = 493,
  parameter int SRC_LSB     = 488,
  parameter int OPND_LSB    = 482,
  parameter int DST_LSB     = 477,
  parameter int LANE_STRIDE = 27,
  parameter int N_CF        = 4,
  parameter logic [N_CF*10-1:0] CF_LIST = {10'h3C3, 10'h3C2, 10'h3C1, 10'h3C0}
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                bundle_valid,
  input  logic [BUNDLE_W-1:0] bundle,
  output logic                out_valid,
  output logic                l0_pred,
  output logic [3:0]          l0_cls,
  output logic [5:0]          l0_sub,
  output logic [4:0]          l0_src,
  output logic [5:0]          l0_opnd,
  output logic [4:0]          l0_dst,
  output logic                l0_issue,
  output logic                l1_pred,
  output logic [3:0]          l1_cls,
  output logic [5:0]          l1_sub,
  output logic [4:0]          l1_src,
  output logic [5:0]          l1_opnd,
  output logic [4:0]          l1_dst,
  output logic                l1_issue,
  output logic                lane1_illegal
);
  localparam int N_LANES  = 2;
  localparam int SLOT_W   = PRED_POS - DST_LSB + 1;
  localparam int LOW_BIT  = DST_LSB - (N_LANES - 1) * LANE_STRIDE;

  // Decoded (combinational) view of each lane and its control-transfer match
  slot_t              dec    [N_LANES];
  logic [N_LANES-1:0] cf_hit;

  for (genvar ln = 0; ln < N_LANES; ln++) begin : g_lane
    logic [SLOT_W-1:0] win;
    assign win = bundle[DST_LSB - ln*LANE_STRIDE +: SLOT_W];

    ssd_slot_extract #(
      .SLOT_W  (SLOT_W),
      .PRED_REL(PRED_POS - DST_LSB),
      .CLS_REL (CLS_LSB  - DST_LSB),
      .SUB_REL (SUB_LSB  - DST_LSB),
      .SRC_REL (SRC_LSB  - DST_LSB),
      .OPND_REL(OPND_LSB - DST_LSB),
      .DST_REL (0)
    ) u_extract (
      .win   (win),
      .fields(dec[ln])
    );

    ssd_cf_match #(
      .N_CF   (N_CF),
      .CF_LIST(CF_LIST)
    ) u_cf (
      .cls(dec[ln].cls),
      .sub(dec[ln].sub),
      .hit(cf_hit[ln])
    );
  end

  // Bits outside both slots carry other units' fields
  logic unused_bundle_bits;
  assign unused_bundle_bits = ^{bundle[BUNDLE_W-1:PRED_POS+1], bundle[LOW_BIT-1:0], cf_hit[0]};

  // Named legality event: control transfer in the restricted lane
  logic l1_violation;
  assign l1_violation = bundle_valid & cf_hit[1];

  slot_t q0, q1;
  logic  vq, ill_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vq    <= 1'b0;
      ill_q <= 1'b0;
      q0    <= '0;
      q1    <= '0;
    end else if (en) begin
      vq    <= bundle_valid;
      ill_q <= l1_violation;
      q0    <= dec[0];
      q1    <= dec[1];
    end
  end

  assign out_valid     = vq;
  assign lane1_illegal = ill_q;
  assign l0_pred = q0.pred;
  assign l0_cls  = q0.cls;
  assign l0_sub  = q0.sub;
  assign l0_src  = q0.src;
  assign l0_opnd = q0.opnd;
  assign l0_dst  = q0.dst;
  assign l1_pred = q1.pred;
  assign l1_cls  = q1.cls;
  assign l1_sub  = q1.sub;
  assign l1_src  = q1.src;
  assign l1_opnd = q1.opnd;
  assign l1_dst  = q1.dst;
  assign l0_issue = vq & q0.pred;
  assign l1_issue = vq & q1.pred & ~ill_q;
endmodule

// File: rtl/ssd_checker.sv
module ssd_checker #(
  parameter int BUNDLE_W    = 512,
  parameter int CLS_LSB     = 499,
  parameter int SUB_LSB     = 493,
  parameter int SRC_LSB     = 488,
  parameter int DST_LSB     = 477,
  parameter int LANE_STRIDE = 27
) (
  input logic                clk,
  input logic                rst_n,
  input logic                en,
  input logic                bundle_valid,
  input logic [BUNDLE_W-1:0] bundle,
  input logic                out_valid,
  input logic                l0_pred,
  input logic [3:0]          l0_cls,
  input logic [5:0]          l0_sub,
  input logic [4:0]          l0_dst,
  input logic                l0_issue,
  input logic                l1_pred,
  input logic [3:0]          l1_cls,
  input logic [4:0]          l1_src,
  input logic                l1_issue,
  input logic                lane1_illegal
);
  a_r3_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> out_valid == $past(bundle_valid));

  a_r1_lane0_fields: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (l0_cls == $past(bundle[CLS_LSB +: 4])) && (l0_sub == $past(bundle[SUB_LSB +: 6]))
           && (l0_dst == $past(bundle[DST_LSB +: 5])));

  a_r2_lane1_fields: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (l1_cls == $past(bundle[CLS_LSB - LANE_STRIDE +: 4]))
           && (l1_src == $past(bundle[SRC_LSB - LANE_STRIDE +: 5])));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(out_valid) && $stable(l0_cls) && $stable(l1_cls) && $stable(lane1_illegal));

  a_r5_l0_issue: assert property (@(posedge clk) disable iff (!rst_n)
    l0_issue == (out_valid && l0_pred));

  a_r6_illegal_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    lane1_illegal |-> !l1_issue);

  a_r7_l1_issue: assert property (@(posedge clk) disable iff (!rst_n)
    l1_issue |-> out_valid && l1_pred);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !l0_issue && !l1_issue && !lane1_illegal);
endmodule

bind scalar_slot_decoder ssd_checker #(
  .BUNDLE_W(BUNDLE_W), .CLS_LSB(CLS_LSB), .SUB_LSB(SUB_LSB), .SRC_LSB(SRC_LSB),
  .DST_LSB(DST_LSB), .LANE_STRIDE(LANE_STRIDE)
) u_ssd_checker (
  .clk(clk), .rst_n(rst_n), .en(en), .bundle_valid(bundle_valid), .bundle(bundle),
  .out_valid(out_valid), .l0_pred(l0_pred), .l0_cls(l0_cls), .l0_sub(l0_sub),
  .l0_dst(l0_dst), .l0_issue(l0_issue), .l1_pred(l1_pred), .l1_cls(l1_cls),
  .l1_src(l1_src), .l1_issue(l1_issue), .lane1_illegal(lane1_illegal)
);

// File: tb/test_scalar_slot_decoder.sv
`timescale 1ns/1ps
module test_scalar_slot_decoder;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b0;
  logic         bundle_valid = 1'b0;
  logic [511:0] bundle = '0;
  logic         out_valid, l0_pred, l0_issue, l1_pred, l1_issue, lane1_illegal;
  logic [3:0]   l0_cls, l1_cls;
  logic [5:0]   l0_sub, l0_opnd, l1_sub, l1_opnd;
  logic [4:0]   l0_src, l0_dst, l1_src, l1_dst;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  scalar_slot_decoder i_scalar_slot_decoder (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Places a slot's fields; top bit of the slot at position top
  function automatic logic [511:0] put_slot(input logic [511:0] b, input int top,
      input logic p, input logic [3:0] c, input logic [5:0] s,
      input logic [4:0] x, input logic [5:0] y, input logic [4:0] d);
    logic [511:0] m, v;
    m = ((512'd1 << 27) - 512'd1) << (top - 26);
    v = {485'd0, p, c, s, x, y, d};
    return (b & ~m) | (v << (top - 26));
  endfunction

  function automatic logic [511:0] rnd_bundle();
    logic [511:0] r;
    for (int i = 0; i < 16; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  function automatic logic is_cf(input logic [3:0] c, input logic [5:0] s);
    return (c == 4'd15) && (s < 6'd4);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [511:0] b;
    logic [26:0]  e0, e1;
    logic [3:0]   c0;
    logic [5:0]   s0;
    logic         p0, p1, ill;
    bundle = rnd_bundle();
    bundle_valid = 1'b1;
    en = 1'b1;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 out_valid", {31'd0, out_valid}, 0);
    chk("R8 issue", {30'd0, l0_issue, l1_issue}, 0);
    chk("R8 illegal", {31'd0, lane1_illegal}, 0);
    chk("R8 fields", {5'd0, l0_pred, l0_cls, l0_sub, l0_src, l0_opnd, l0_dst}, 0);
    rst_n = 1'b1;

    // Sweep every lane-1 (class, sub-operation); lane 0 cycles through control transfers too
    for (int k = 0; k < 1024; k++) begin
      @(negedge clk);
      c0 = (k % 3 == 0) ? 4'd15 : 4'($urandom);
      s0 = (k % 3 == 0) ? 6'(k % 5) : 6'($urandom);
      p0 = k[1];
      p1 = k[0] ^ k[5];
      b = rnd_bundle();
      e0 = {p0, c0, s0, 5'($urandom), 6'($urandom), 5'($urandom)};
      e1 = {p1, 4'(k >> 6), 6'(k), 5'($urandom), 6'($urandom), 5'($urandom)};
      b = put_slot(b, 503, e0[26], e0[25:22], e0[21:16], e0[15:11], e0[10:5], e0[4:0]);
      b = put_slot(b, 503 - 27, e1[26], e1[25:22], e1[21:16], e1[15:11], e1[10:5], e1[4:0]);
      bundle = b;
      bundle_valid = 1'b1;
      @(negedge clk);
      ill = is_cf(e1[25:22], e1[21:16]);
      chk("R3 out_valid", {31'd0, out_valid}, 1);
      chk("R1 lane0 fields", {5'd0, l0_pred, l0_cls, l0_sub, l0_src, l0_opnd, l0_dst}, {5'd0, e0});
      chk("R2 lane1 fields", {5'd0, l1_pred, l1_cls, l1_sub, l1_src, l1_opnd, l1_dst}, {5'd0, e1});
      chk("R6 lane1_illegal", {31'd0, lane1_illegal}, {31'd0, ill});
      chk("R5 l0_issue", {31'd0, l0_issue}, {31'd0, p0});
      chk("R7 l1_issue", {31'd0, l1_issue}, {31'd0, p1 & ~ill});
    end

    // R9: invalid bundle containing a lane-1 control transfer
    b = put_slot(rnd_bundle(), 476, 1'b1, 4'd15, 6'd2, 5'd3, 6'd4, 5'd5);
    b = put_slot(b, 503, 1'b1, 4'd1, 6'd1, 5'd1, 6'd1, 5'd1);
    bundle = b;
    bundle_valid = 1'b0;
    @(negedge clk);
    chk("R9 out_valid low", {31'd0, out_valid}, 0);
    chk("R9 quiet", {29'd0, l0_issue, l1_issue, lane1_illegal}, 0);
    chk("R9 fields reported", {28'd0, l1_cls}, 15);

    // R4: load an illegal bundle, then drop en and change inputs
    bundle_valid = 1'b1;
    @(negedge clk);
    chk("R6 illegal flagged", {31'd0, lane1_illegal}, 1);
    en = 1'b0;
    bundle_valid = 1'b0;
    bundle = put_slot(rnd_bundle(), 476, 1'b0, 4'd2, 6'd9, 5'd0, 6'd0, 5'd0);
    repeat (3) @(negedge clk);
    chk("R4 hold valid", {31'd0, out_valid}, 1);
    chk("R4 hold illegal", {31'd0, lane1_illegal}, 1);
    chk("R4 hold lane1", {22'd0, l1_cls, l1_sub}, {22'd0, 4'd15, 6'd2});
    chk("R4 hold lane0", {28'd0, l0_cls}, 1);
    en = 1'b1;
    @(negedge clk);
    chk("R3 reenable", {31'd0, out_valid}, 0);
    chk("R3 reenable fields", {22'd0, l1_cls, l1_sub}, {22'd0, 4'd2, 6'd9});

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule